// File: doc/BRIEF.md
# Serial Channel Diagnostic Mode Router

This block sits between one serial receiver, one serial transmitter, the host side and the two line pins of a serial channel. A two-bit mode selects how data and bit clocks are steered. In normal operation the transmitter and receiver run independently. In automatic echo the block retimes the incoming line and drives it back out. In local loopback the transmitter feeds the receiver internally. In remote loopback the line is retimed and returned while nothing reaches the host. The block also masks the transmitter status, the receiver status and the host write strobe as each mode requires, and tells the receiver whether to check parity and framing.

The shift registers, baud generators and FIFOs live outside. The block sees only serial bit streams, bit-clock strobes (a 16x oversampling strobe on each side) and status strobes. A requested mode is copied into the active mode only in a cycle in which both the receiver and the transmitter report idle. Until then the request stays pending and the old mode keeps routing.

Top module: `ser_diag_router`

## Requirements
- R1: Active mode code 0 is normal. `txd` follows `tx_ser`, `rx_ser` follows `rxd`, each tick output follows its own side's tick, and all status and strobes pass through unchanged. Codes 1, 2 and 3 are automatic echo, local loopback and remote loopback.
- R2: After reset `mode_act` is 0. At each clock edge where `rx_idle` and `tx_idle` are both high, `mode_act` takes `mode_req`. At any other edge it holds, so the request stays pending.
- R3: In echo (1) and remote (3) modes, `txd` is the retimed line and `tx_tick_o` follows `rx_tick`. In echo mode, `tx_wr` is held low.
- R4: In echo mode, `tx_rdy` and `tx_emt` are held low. `rx_err`, `rx_valid` and `rx_chk_en` (high) still reach the receiver side as in normal mode.
- R5: In remote mode, `rx_valid`, every bit of `rx_err`, and `rx_chk_en` are held low.
- R6: In local mode, `rx_ser` follows `tx_ser`, `rx_tick_o` follows `tx_tick`, `txd` is held high and `rxd` has no effect on any output.
- R7: Retiming stage. Every `rx_tick` cycle loads the previous-line register with `rxd`. A tick that sees the previous value high and `rxd` low sets the phase to 1. Every other tick increments the phase, modulo 16. On a tick where the phase is 8, the retimed line takes `rxd` and then holds it for the whole following bit period. A held-low line (break) is therefore echoed low until it rises and the next falling edge restarts the phase. After reset the retimed line and the previous-line register are high and the phase is 0.
- R8: `tx_run` is low in echo and remote modes and equals `tx_en` otherwise. `rx_run` equals `rx_en | tx_en` in local mode and `rx_en` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode |
| rx_idle | input | 1 | Receiver reports idle |
| tx_idle | input | 1 | Transmitter reports idle |
| rx_en | input | 1 | Host receiver enable |
| tx_en | input | 1 | Host transmitter enable |
| rxd | input | 1 | Line input pin |
| tx_ser | input | 1 | Transmitter serial output |
| rx_tick | input | 1 | Receive 16x strobe |
| tx_tick | input | 1 | Transmit 16x strobe |
| tx_rdy_raw | input | 1 | Transmitter ready from FIFO logic |
| tx_emt_raw | input | 1 | Transmitter empty from FIFO logic |
| rx_err_raw | input | ERRW | Receiver error flags |
| rx_valid_raw | input | 1 | Received character strobe |
| host_tx_wr | input | 1 | Host write to transmitter |
| txd | output | 1 | Line output pin |
| rx_ser | output | 1 | Serial input to receiver |
| rx_tick_o | output | 1 | Strobe driving the receiver |
| tx_tick_o | output | 1 | Strobe driving the transmitter |
| rx_run | output | 1 | Receiver effective enable |
| tx_run | output | 1 | Transmitter effective enable |
| rx_chk_en | output | 1 | Parity and framing check enable |
| tx_rdy | output | 1 | Host-visible transmitter ready |
| tx_emt | output | 1 | Host-visible transmitter empty |
| rx_err | output | ERRW | Host-visible error flags |
| rx_valid | output | 1 | Host-visible character strobe |
| tx_wr | output | 1 | Write strobe to transmitter |
| mode_act | output | 2 | Active mode |

## Verification
A wrong mode register appears at once at `mode_act`, and in the same cycle as wrong routing on every mux output. Idle patterns that leave a request pending for many cycles make a premature switch visible in the first cycle it happens. A wrong retiming phase shows on `txd` in echo and remote modes at the first bit centre after a falling edge, which is at most 16 receive ticks later. Long breaks and ticks that skip cycles expose counting errors within one bit period.

// File: rtl/ser_route_pkg.sv
package ser_route_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ECHO   = 2'd1,
        MODE_LOCAL  = 2'd2,
        MODE_REMOTE = 2'd3
    } mode_e;

    typedef struct packed {
        logic echo_line;      // line out is the retimed line
        logic loop_in;        // receiver fed from transmitter
        logic tx_clk_from_rx; // transmitter strobe from receive side
        logic rx_clk_from_tx; // receiver strobe from transmit side
        logic host_tx_block;  // host write strobe suppressed
        logic tx_stat_mask;   // transmitter status forced low
        logic rx_host_mask;   // receiver status and data hidden
        logic txd_high;       // line out forced to mark
        logic tx_park;        // transmitter run forced low
    } route_t;

    function automatic route_t decode_mode(mode_e m);
        route_t r;
        r                = '0;
        r.echo_line      = (m == MODE_ECHO) || (m == MODE_REMOTE);
        r.tx_clk_from_rx = r.echo_line;
        r.tx_park        = r.echo_line;
        r.loop_in        = (m == MODE_LOCAL);
        r.rx_clk_from_tx = (m == MODE_LOCAL);
        r.txd_high       = (m == MODE_LOCAL);
        r.host_tx_block  = (m == MODE_ECHO);
        r.tx_stat_mask   = (m == MODE_ECHO);
        r.rx_host_mask   = (m == MODE_REMOTE);
        return r;
    endfunction

endpackage

// File: rtl/sr_mode_reg.sv
module sr_mode_reg
    import ser_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic       rx_idle,
    input  logic       tx_idle,
    output mode_e      mode_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_NORMAL;
        else if (rx_idle && tx_idle)
            mode_q <= mode_e'(mode_req);
    end
endmodule

// File: rtl/sr_echo_reclk.sv
module sr_echo_reclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    output logic line
);
    localparam int             CW  = $clog2(OVS);
    localparam logic [CW-1:0]  CTR = CW'(OVS / 2);
    localparam logic [CW-1:0]  ONE = CW'(1);

    logic          prev_q;
    logic [CW-1:0] ph_q;
    logic          fall;

    assign fall = prev_q & ~rxd;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            ph_q   <= '0;
            line   <= 1'b1;
        end else if (tick) begin
            prev_q <= rxd;
            ph_q   <= fall ? ONE : ph_q + ONE;
            if (ph_q == CTR)
                line <= rxd;
        end
    end
endmodule

// File: rtl/sr_route_mux.sv
module sr_route_mux
    import ser_route_pkg::*;
#(
    parameter int ERRW = 3
) (
    input  mode_e            mode,
    input  logic             echo_line,
    input  logic             rxd,
    input  logic             tx_ser,
    input  logic             rx_tick,
    input  logic             tx_tick,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             tx_rdy_raw,
    input  logic             tx_emt_raw,
    input  logic [ERRW-1:0]  rx_err_raw,
    input  logic             rx_valid_raw,
    input  logic             host_tx_wr,
    output logic             txd,
    output logic             rx_ser,
    output logic             rx_tick_o,
    output logic             tx_tick_o,
    output logic             rx_run,
    output logic             tx_run,
    output logic             rx_chk_en,
    output logic             tx_rdy,
    output logic             tx_emt,
    output logic [ERRW-1:0]  rx_err,
    output logic             rx_valid,
    output logic             tx_wr
);
    route_t r;

    always_comb begin
        r         = decode_mode(mode);
        txd       = r.txd_high ? 1'b1 : (r.echo_line ? echo_line : tx_ser);
        rx_ser    = r.loop_in ? tx_ser : rxd;
        rx_tick_o = r.rx_clk_from_tx ? tx_tick : rx_tick;
        tx_tick_o = r.tx_clk_from_rx ? rx_tick : tx_tick;
        rx_run    = r.loop_in ? (rx_en | tx_en) : rx_en;
        tx_run    = r.tx_park ? 1'b0 : tx_en;
        rx_chk_en = ~r.rx_host_mask;
        tx_rdy    = tx_rdy_raw & ~r.tx_stat_mask;
        tx_emt    = tx_emt_raw & ~r.tx_stat_mask;
        rx_err    = r.rx_host_mask ? '0 : rx_err_raw;
        rx_valid  = rx_valid_raw & ~r.rx_host_mask;
        tx_wr     = host_tx_wr & ~r.host_tx_block;
    end
endmodule

// File: rtl/ser_diag_router.sv
module ser_diag_router
    import ser_route_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int ERRW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_req,
    input  logic             rx_idle,
    input  logic             tx_idle,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             rxd,
    input  logic             tx_ser,
    input  logic             rx_tick,
    input  logic             tx_tick,
    input  logic             tx_rdy_raw,
    input  logic             tx_emt_raw,
    input  logic [ERRW-1:0]  rx_err_raw,
    input  logic             rx_valid_raw,
    input  logic             host_tx_wr,
    output logic             txd,
    output logic             rx_ser,
    output logic             rx_tick_o,
    output logic             tx_tick_o,
    output logic             rx_run,
    output logic             tx_run,
    output logic             rx_chk_en,
    output logic             tx_rdy,
    output logic             tx_emt,
    output logic [ERRW-1:0]  rx_err,
    output logic             rx_valid,
    output logic             tx_wr,
    output logic [1:0]       mode_act
);
    mode_e mode_q;
    logic  echo_line;

    sr_mode_reg u_mode (
        .clk(clk), .rst(rst), .mode_req(mode_req),
        .rx_idle(rx_idle), .tx_idle(tx_idle), .mode_q(mode_q)
    );

    sr_echo_reclk #(.OVS(OVS)) u_reclk (
        .clk(clk), .rst(rst), .tick(rx_tick), .rxd(rxd), .line(echo_line)
    );

    sr_route_mux #(.ERRW(ERRW)) u_mux (
        .mode(mode_q), .echo_line(echo_line), .rxd(rxd), .tx_ser(tx_ser),
        .rx_tick(rx_tick), .tx_tick(tx_tick), .rx_en(rx_en), .tx_en(tx_en),
        .tx_rdy_raw(tx_rdy_raw), .tx_emt_raw(tx_emt_raw),
        .rx_err_raw(rx_err_raw), .rx_valid_raw(rx_valid_raw),
        .host_tx_wr(host_tx_wr), .txd(txd), .rx_ser(rx_ser),
        .rx_tick_o(rx_tick_o), .tx_tick_o(tx_tick_o), .rx_run(rx_run),
        .tx_run(tx_run), .rx_chk_en(rx_chk_en), .tx_rdy(tx_rdy),
        .tx_emt(tx_emt), .rx_err(rx_err), .rx_valid(rx_valid), .tx_wr(tx_wr)
    );

    assign mode_act = mode_q;
endmodule

// File: rtl/sr_router_chk.sv
module sr_router_chk #(
    parameter int ERRW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode_req,
    input logic            rx_idle,
    input logic            tx_idle,
    input logic            rx_tick,
    input logic            tx_tick,
    input logic            tx_ser,
    input logic            txd,
    input logic            rx_ser,
    input logic            rx_tick_o,
    input logic            tx_tick_o,
    input logic            tx_rdy,
    input logic            tx_emt,
    input logic            tx_wr,
    input logic            tx_run,
    input logic            rx_chk_en,
    input logic [ERRW-1:0] rx_err,
    input logic            rx_valid,
    input logic [1:0]      mode_act
);
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(rx_idle && tx_idle) |=> $stable(mode_act)); // R2
    AST_MODE_TAKE: assert property (@(posedge clk) disable iff (rst)
        (rx_idle && tx_idle) |=> (mode_act == $past(mode_req))); // R2
    AST_ECHO_MASK: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'd1) |-> (!tx_rdy && !tx_emt && !tx_wr && rx_chk_en)); // R4
    AST_REMOTE_MASK: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'd3) |-> (rx_err == '0 && !rx_valid && !rx_chk_en)); // R5
    AST_LOCAL_LOOP: assert property (@(posedge clk) disable iff (rst)
        (mode_act == 2'd2) |-> (txd && rx_ser == tx_ser && rx_tick_o == tx_tick)); // R6
    AST_ECHO_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (mode_act[0]) |-> (tx_tick_o == rx_tick && !tx_run)); // R3
    AST_ECHO_RETIME: assert property (@(posedge clk) disable iff (rst)
        (mode_act[0] && mode_act == $past(mode_act) && !$past(rx_tick))
        |-> $stable(txd)); // R7
endmodule

bind ser_diag_router sr_router_chk #(.ERRW(ERRW)) u_chk (
    .clk(clk), .rst(rst), .mode_req(mode_req), .rx_idle(rx_idle),
    .tx_idle(tx_idle), .rx_tick(rx_tick), .tx_tick(tx_tick), .tx_ser(tx_ser),
    .txd(txd), .rx_ser(rx_ser), .rx_tick_o(rx_tick_o), .tx_tick_o(tx_tick_o),
    .tx_rdy(tx_rdy), .tx_emt(tx_emt), .tx_wr(tx_wr), .tx_run(tx_run),
    .rx_chk_en(rx_chk_en), .rx_err(rx_err), .rx_valid(rx_valid),
    .mode_act(mode_act)
);

// File: tb/test_ser_diag_router.sv
module test_ser_diag_router;
    localparam int ERRW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_req = 2'd0;
    logic rx_idle = 1'b0, tx_idle = 1'b0, rx_en = 1'b0, tx_en = 1'b0;
    logic rxd = 1'b1, tx_ser = 1'b1, rx_tick = 1'b0, tx_tick = 1'b0;
    logic tx_rdy_raw = 1'b0, tx_emt_raw = 1'b0, rx_valid_raw = 1'b0, host_tx_wr = 1'b0;
    logic [ERRW-1:0] rx_err_raw = '0;
    logic txd, rx_ser, rx_tick_o, tx_tick_o, rx_run, tx_run, rx_chk_en;
    logic tx_rdy, tx_emt, rx_valid, tx_wr;
    logic [ERRW-1:0] rx_err;
    logic [1:0] mode_act;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ser_diag_router #(.OVS(16), .ERRW(ERRW)) i_ser_diag_router (
        .clk(clk), .rst(rst), .mode_req(mode_req), .rx_idle(rx_idle),
        .tx_idle(tx_idle), .rx_en(rx_en), .tx_en(tx_en), .rxd(rxd),
        .tx_ser(tx_ser), .rx_tick(rx_tick), .tx_tick(tx_tick),
        .tx_rdy_raw(tx_rdy_raw), .tx_emt_raw(tx_emt_raw),
        .rx_err_raw(rx_err_raw), .rx_valid_raw(rx_valid_raw),
        .host_tx_wr(host_tx_wr), .txd(txd), .rx_ser(rx_ser),
        .rx_tick_o(rx_tick_o), .tx_tick_o(tx_tick_o), .rx_run(rx_run),
        .tx_run(tx_run), .rx_chk_en(rx_chk_en), .tx_rdy(tx_rdy),
        .tx_emt(tx_emt), .rx_err(rx_err), .rx_valid(rx_valid),
        .tx_wr(tx_wr), .mode_act(mode_act)
    );

    // Behavioural reference state
    int m_mode = 0;
    int m_phase = 0;
    bit m_prev = 1'b1;
    bit m_line = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_phase = 0; m_prev = 1'b1; m_line = 1'b1;
        end else begin
            if (rx_idle && tx_idle) m_mode = int'(mode_req);
            if (rx_tick) begin
                if (m_phase == 8) m_line = rxd;
                if (m_prev && !rxd) m_phase = 1;
                else m_phase = (m_phase + 1) % 16;
                m_prev = rxd;
            end
        end
    end

    task automatic chk(string req, string nm, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rq;
        bit e_txd;
        rq = (m_mode == 0) ? "R1" : (m_mode == 1) ? "R3" : (m_mode == 2) ? "R6" : "R5";
        chk("R2", "mode_act", int'(mode_act), m_mode);
        e_txd = (m_mode == 0) ? tx_ser : (m_mode == 2) ? 1'b1 : m_line;
        chk((m_mode == 1 || m_mode == 3) ? "R7" : rq, "txd", int'(txd), int'(e_txd));
        chk(rq, "rx_ser", int'(rx_ser), int'((m_mode == 2) ? tx_ser : rxd));
        chk(rq, "rx_tick_o", int'(rx_tick_o), int'((m_mode == 2) ? tx_tick : rx_tick));
        chk("R3", "tx_tick_o", int'(tx_tick_o),
            int'((m_mode == 1 || m_mode == 3) ? rx_tick : tx_tick));
        chk("R8", "rx_run", int'(rx_run), int'((m_mode == 2) ? (rx_en | tx_en) : rx_en));
        chk("R8", "tx_run", int'(tx_run), int'((m_mode == 1 || m_mode == 3) ? 1'b0 : tx_en));
        chk("R5", "rx_chk_en", int'(rx_chk_en), (m_mode == 3) ? 0 : 1);
        chk("R4", "tx_rdy", int'(tx_rdy), (m_mode == 1) ? 0 : int'(tx_rdy_raw));
        chk("R4", "tx_emt", int'(tx_emt), (m_mode == 1) ? 0 : int'(tx_emt_raw));
        chk("R5", "rx_err", int'(rx_err), (m_mode == 3) ? 0 : int'(rx_err_raw));
        chk("R5", "rx_valid", int'(rx_valid), (m_mode == 3) ? 0 : int'(rx_valid_raw));
        chk("R3", "tx_wr", int'(tx_wr), (m_mode == 1) ? 0 : int'(host_tx_wr));
    endtask

    // Line stimulus: queue of bits, each held for 16 receive ticks
    bit line_q[$];
    int tick_cnt = 0;

    task automatic refill();
        if ($urandom_range(0, 7) == 0) begin
            for (int i = 0; i < 30; i++) line_q.push_back(1'b0); // break
            for (int i = 0; i < 2; i++)  line_q.push_back(1'b1);
        end else begin
            line_q.push_back(1'b0);
            for (int i = 0; i < 8; i++) line_q.push_back(1'($urandom_range(0, 1)));
            for (int i = 0; i < 1 + $urandom_range(0, 2); i++) line_q.push_back(1'b1);
        end
    endtask

    task automatic drive_cycle(int idle_pct);
        rx_tick      = ($urandom_range(0, 9) != 0);
        tx_tick      = 1'($urandom_range(0, 1));
        tx_ser       = 1'($urandom_range(0, 1));
        rx_en        = 1'($urandom_range(0, 1));
        tx_en        = 1'($urandom_range(0, 1));
        tx_rdy_raw   = 1'($urandom_range(0, 1));
        tx_emt_raw   = 1'($urandom_range(0, 1));
        rx_valid_raw = 1'($urandom_range(0, 1));
        host_tx_wr   = 1'($urandom_range(0, 1));
        rx_err_raw   = ERRW'($urandom_range(0, (1 << ERRW) - 1));
        rx_idle      = ($urandom_range(0, 99) < idle_pct);
        tx_idle      = ($urandom_range(0, 99) < idle_pct);
        if (rx_tick) begin
            tick_cnt++;
            if (tick_cnt >= 16) begin
                tick_cnt = 0;
                if (line_q.size() == 0) refill();
                rxd = line_q.pop_front();
            end
        end
    endtask

    task automatic step(int idle_pct);
        @(negedge clk);
        compare_all();
        drive_cycle(idle_pct);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state: mode 0, retimed line high (R2, R7)
        chk("R2", "reset mode_act", int'(mode_act), 0);
        chk("R1", "reset txd", int'(txd), int'(tx_ser));
        rst = 1'b0;
        // Each mode in turn; first stretch keeps a change pending (R2)
        for (int m = 1; m < 4; m++) begin
            mode_req = 2'(m);
            for (int c = 0; c < 40; c++) step(0);
            chk("R2", "pending hold", int'(mode_act), m_mode);
            for (int c = 0; c < 5; c++) step(100);
            chk("R2", "mode taken", int'(mode_act), m);
            for (int c = 0; c < 900; c++) step(0);
        end
        mode_req = 2'd0;
        for (int c = 0; c < 300; c++) step(100);
        // Random mode changes with partial idle (R1..R8)
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 59) == 0) mode_req = 2'($urandom_range(0, 3));
            step(60);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule